// File: doc/BRIEF.md
# Multi-Mode GPIO Output Register

This block keeps the output levels of a bank of fast general-purpose output channels (eight by default, set by a parameter). Software changes those levels over a simple synchronous register bus in one of three ways: a whole-word write, a write that only reaches the channels picked out by a mask, or a command write in which every channel carries its own two-bit command to set, clear, invert or keep its level. A single command write can therefore act on any subset of channels at once.

A per-channel enable register decides which channels are actually driven from this register. A channel whose enable bit is low shows 0 on its pin, whatever level is stored for it. The stored levels can be read back as one status word, and the enable register can be read back for read-modify-write updates. Reads are combinational from the address. Writes take effect on the clock edge that samples the write strobe.

Top module: `gpo_bank`

## Requirements
- R1: After reset the stored levels and the enable bits are all 0, so every pin reads 0.
- R2: A write to address 0 replaces the stored level of every channel with bits [N-1:0] of the write data on the next clock edge.
- R3: A write to address 1 updates only the channels whose mask bit (write data [N-1:0]) is 1. Each such channel takes its value bit from write data [2N-1:N]. All other channels keep their level.
- R4: A write to address 2 gives channel n the command in write data [2n+1:2n]: 2'b01 sets the level, 2'b10 clears it, 2'b11 inverts it, and 2'b00 leaves it unchanged.
- R5: A read at address 4 returns the stored levels in bits [N-1:0], with the upper bits 0.
- R6: A write to address 3 loads the enable bits from write data [N-1:0]. A read at address 3 returns them in bits [N-1:0].
- R7: Pin n equals the stored level of channel n when enable bit n is 1, and is 0 when enable bit n is 0.
- R8: With the write strobe low, and on writes to address 4 or to addresses 5 to 7, neither the stored levels nor the enable bits change.
- R9: Reads at addresses 0, 1, 2 and 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Register address for both reads and writes |
| bus_wdata | input | 2N | Write data |
| bus_rdata | output | 2N | Read data, combinational from bus_addr |
| pin_out | output | N | Gated channel outputs to the pads |

## Verification
The assertions assume that the write strobe and the address are always known values and change only between clock edges. Under that assumption, every cycle with the strobe high counts as exactly one register access. The bench changes the bus only on falling edges and holds each access for a single cycle. The random addresses it draws cover the full 3-bit range, so writes to the unused and read-only addresses also occur. The random data it draws covers the whole 2N-bit word, so every command code appears in every channel field.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_FULL   = 3'd0,
        ADDR_MASKED = 3'd1,
        ADDR_CMD    = 3'd2,
        ADDR_ENABLE = 3'd3,
        ADDR_STATUS = 3'd4
    } gpo_addr_e;

    typedef enum logic [1:0] {
        CMD_KEEP = 2'b00,
        CMD_SET  = 2'b01,
        CMD_CLR  = 2'b10,
        CMD_FLIP = 2'b11
    } chan_cmd_e;

    typedef struct packed {
        logic full;
        logic masked;
        logic cmd;
        logic enable;
    } wr_sel_t;

    // Next level of one channel under a two-bit command
    function automatic logic chan_apply(input logic cur, input chan_cmd_e c);
        logic nxt;
        case (c)
            CMD_SET:  nxt = 1'b1;
            CMD_CLR:  nxt = 1'b0;
            CMD_FLIP: nxt = ~cur;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gpo_decode.sv
module gpo_decode
    import gpo_pkg::*;
(
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_sel_t           sel
);
    always_comb begin
        sel = '0;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_FULL:   sel.full   = 1'b1;
                ADDR_MASKED: sel.masked = 1'b1;
                ADDR_CMD:    sel.cmd    = 1'b1;
                ADDR_ENABLE: sel.enable = 1'b1;
                default:     sel        = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpo_state.sv
module gpo_state
    import gpo_pkg::*;
#(
    parameter int N = 8,
    localparam int DW = 2 * N
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_sel_t       sel,
    input  logic [DW-1:0] wdata,
    output logic [N-1:0]  level_q
);
    logic [N-1:0] level_d;

    for (genvar i = 0; i < N; i++) begin : g_chan
        chan_cmd_e cmd_i;
        assign cmd_i = chan_cmd_e'(wdata[2*i +: 2]);

        always_comb begin
            level_d[i] = level_q[i];
            if (sel.full)
                level_d[i] = wdata[i];
            else if (sel.masked && wdata[i])
                level_d[i] = wdata[N + i];
            else if (sel.cmd)
                level_d[i] = chan_apply(level_q[i], cmd_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= '0;
        else
            level_q <= level_d;
    end
endmodule

// File: rtl/gpo_enable.sv
module gpo_enable #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (load)
            en_q <= wdata;
    end
endmodule

// File: rtl/gpo_readmux.sv
module gpo_readmux
    import gpo_pkg::*;
#(
    parameter int N = 8,
    localparam int DW = 2 * N
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      level,
    input  logic [N-1:0]      en,
    output logic [DW-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_STATUS: rdata[N-1:0] = level;
            ADDR_ENABLE: rdata[N-1:0] = en;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpo_bank.sv
module gpo_bank
    import gpo_pkg::*;
#(
    parameter int N = 8,
    localparam int DW = 2 * N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [N-1:0]      pin_out
);
    wr_sel_t      sel;
    logic [N-1:0] level_q;
    logic [N-1:0] en_q;

    gpo_decode u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .sel      (sel)
    );

    gpo_state #(.N(N)) u_state (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wdata   (bus_wdata),
        .level_q (level_q)
    );

    gpo_enable #(.N(N)) u_en (
        .clk   (clk),
        .rst   (rst),
        .load  (sel.enable),
        .wdata (bus_wdata[N-1:0]),
        .en_q  (en_q)
    );

    gpo_readmux #(.N(N)) u_rd (
        .addr  (bus_addr),
        .level (level_q),
        .en    (en_q),
        .rdata (bus_rdata)
    );

    assign pin_out = level_q & en_q;
endmodule

// File: rtl/gpo_bank_chk.sv
module gpo_bank_chk #(
    parameter int N = 8,
    localparam int DW = 2 * N
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic [2:0]    bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [N-1:0]  pin_out,
    input logic [N-1:0]  level_q,
    input logic [N-1:0]  en_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (level_q == '0 && en_q == '0));

    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0) |=> level_q == $past(bus_wdata[N-1:0]));

    // R3
    masked_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd1)
        |=> ((level_q ^ $past(level_q)) & ~$past(bus_wdata[N-1:0])) == '0);

    for (genvar i = 0; i < N; i++) begin : g_cmd
        // R4
        cmd_flip_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == 3'd2 && bus_wdata[2*i +: 2] == 2'b11)
            |=> level_q[i] != $past(level_q[i]));
        // R4
        cmd_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == 3'd2 && bus_wdata[2*i +: 2] == 2'b00)
            |=> $stable(level_q[i]));
    end

    // R6
    enable_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd3) |=> en_q == $past(bus_wdata[N-1:0]));

    // R7
    pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~en_q) == '0);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr || bus_addr >= 3'd4) |=> ($stable(level_q) && $stable(en_q)));
endmodule

bind gpo_bank gpo_bank_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .level_q   (level_q),
    .en_q      (en_q)
);

// File: tb/sim_gpo_bank.sv
module sim_gpo_bank;
    localparam int N = 8;
    localparam int DW = 2 * N;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  pin_out;

    int n_checks = 0;
    int n_fail = 0;
    logic [N-1:0] m_level = '0;
    logic [N-1:0] m_en = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpo_bank #(.N(N)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out)
    );

    function automatic logic [N-1:0] next_level(input logic [N-1:0] cur,
                                                input logic [2:0] a,
                                                input logic [DW-1:0] d);
        logic [N-1:0] r;
        r = cur;
        if (a == 3'd0) r = d[N-1:0];
        else if (a == 3'd1) r = (cur & ~d[N-1:0]) | (d[DW-1:N] & d[N-1:0]);
        else if (a == 3'd2) begin
            for (int i = 0; i < N; i++) begin
                case (d[2*i +: 2])
                    2'b01: r[i] = 1'b1;
                    2'b10: r[i] = 1'b0;
                    2'b11: r[i] = ~cur[i];
                    default: r[i] = cur[i];
                endcase
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        m_level = next_level(m_level, a, d);
        if (a == 3'd3) m_en = d[N-1:0];
    endtask

    task automatic read_check(input string tag, input logic [2:0] a, input logic [DW-1:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic check_all(input string tag);
        read_check({tag, " status R5"}, 3'd4, {{N{1'b0}}, m_level});
        read_check({tag, " enable R6"}, 3'd3, {{N{1'b0}}, m_en});
        check({tag, " pins R7"}, {{N{1'b0}}, pin_out}, {{N{1'b0}}, m_level & m_en});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        logic [2:0] a;
        logic [DW-1:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        bus_write(3'd3, 16'h00FF);
        check_all("R6 enable all");
        bus_write(3'd0, 16'hFFA5);
        check_all("R2 full write");
        bus_write(3'd1, 16'h3C0F);
        check_all("R3 masked");
        bus_write(3'd1, 16'hFF00);
        check_all("R3 empty mask");
        bus_write(3'd2, 16'h1B4E);
        check_all("R4 mixed commands");
        bus_write(3'd2, 16'hFFFF);
        check_all("R4 toggle all");
        bus_write(3'd2, 16'h0000);
        check_all("R4 keep all");
        bus_write(3'd3, 16'hFF0A);
        check_all("R7 partial enable");
        bus_write(3'd4, 16'hFFFF);
        check_all("R8 write status ignored");
        bus_write(3'd7, 16'h0000);
        check_all("R8 write unused ignored");
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 16'hFFFF;
        @(negedge clk);
        check_all("R8 strobe low");
        for (int k = 0; k < 8; k++)
            if (k < 3 || k > 4) read_check("R9 empty read", 3'(k), '0);

        for (int k = 0; k < 400; k++) begin
            a = 3'($urandom_range(0, 7));
            d = DW'($urandom);
            bus_write(a, d);
            check_all("random R2 R3 R4 R6 R8");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule